// File: doc/BRIEF.md
# Threshold Local Maximum Finder

This block scans a two-dimensional histogram whose bins are indexed by curvature class and by phi. The histogram arrives one phi column per cycle. Each column is a vector of `N_CLASS` 8-bit counters, one for every curvature class, all at the same phi position. The block holds the two most recent columns in registers. When the next column arrives, it judges every bin of the middle column against its eight neighbours and against a programmable threshold.

Each bin that qualifies becomes a record holding its class index, its phi position and its count. Classes are split into groups of `GRP_SIZE`. Every group has its own small output queue with a valid/ready handshake. When a group has several peaks in one column, they are drained into its queue one per cycle. The input stream is stalled only when a group cannot keep up. An end-of-frame strobe evaluates the last column and restarts the phi numbering.

Top module: `lmf_peak_finder`

## Requirements
- R1: A bin is reported only if its count is strictly greater than `thresh_i`. `thresh_i` is held constant for the whole frame.
- R2: A bin above the threshold is reported when it meets two conditions. It is strictly greater than each neighbour that comes earlier in the order (phi, then class), and greater than or equal to each neighbour that comes later. In a plateau, only the earliest bin is reported.
- R3: Neighbours outside the frame read as zero. This applies before phi 0, after the last column, below class 0 and above class `N_CLASS-1`. A peak in a corner is therefore reported.
- R4: A record carries three fields. The first is the class index. The second is the phi position, counted from 0 for the first column accepted after reset or after an end of frame. The third is the bin's count. A record leaves on queue `class / GRP_SIZE`.
- R5: Within one queue, records appear in ascending phi order, and in ascending class order within the same phi.
- R6: A column is taken on a cycle with `col_valid_i` and `col_ready_o` both high. `col_ready_o` is high when every group has at most one pending peak and can place it in its queue in the current cycle. A full queue therefore stalls the input, and no record is dropped.
- R7: While a queue's valid is high and its ready is low, the valid stays high and the record fields stay unchanged.
- R8: `eof_i` counts only on a cycle with `col_valid_i` low and `col_ready_o` high. It evaluates the last column with an all-zero next column and restarts phi at 0. `eof_i` raised together with `col_valid_i` has no effect: that column is treated as a normal column.
- R9: After reset, no queue is valid and `col_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| thresh_i | input | 8 | reporting threshold |
| col_valid_i | input | 1 | a column is offered |
| col_data_i | input | N_CLASS*8 | counters, class c in bits [8c+7:8c] |
| eof_i | input | 1 | end of frame strobe |
| col_ready_o | output | 1 | column or end of frame can be taken |
| rec_valid_o | output | N_GRP | record available, one bit per group |
| rec_ready_i | input | N_GRP | record consumed, one bit per group |
| rec_class_o | output | N_GRP*3 | class index per group |
| rec_phi_o | output | N_GRP*10 | phi position per group |
| rec_cnt_o | output | N_GRP*8 | bin count per group |

## Verification
A corrupted column window or a wrong neighbour comparison shows at the ports as a missing, extra or misplaced record. It appears two or three cycles after the column that follows the affected one is taken. A mis-stepped drain mask or queue pointer shows as records that are repeated, lost or out of order on one group. The bench holds an ordered expectation per group and compares every record handed over on every clock, so such a fault is seen at the first handshake that carries it. A stall fault shows either as a lost record under a blocked queue or as a stream that never resumes.

// File: rtl/lmf_pkg.sv
package lmf_pkg;
  localparam int CNT_W = 8;
  localparam int PHI_W = 10;
endpackage

// File: rtl/lmf_fifo.sv
module lmf_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] dout_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pop;

  assign full_o  = cnt == (AW+1)'(DEPTH);
  assign valid_o = cnt != '0;
  assign dout_o  = mem[rp];
  assign pop     = valid_o & ready_i;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)    rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push_i) - (AW+1)'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(dout_o)); // R7
endmodule

// File: rtl/lmf_column_window.sv
module lmf_column_window import lmf_pkg::*; #(
  parameter int N_CLASS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic                     flush_i,
  input  logic [N_CLASS*CNT_W-1:0] col_i,
  output logic [N_CLASS*CNT_W-1:0] prev_o,
  output logic [N_CLASS*CNT_W-1:0] cent_o,
  output logic                     cent_valid_o,
  output logic [PHI_W-1:0]         cent_phi_o
);
  logic [N_CLASS*CNT_W-1:0] c1_q, c2_q;
  logic                     have1_q, have2_q;
  logic [PHI_W-1:0]         nxt_phi_q, c1_phi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q      <= '0;
      c2_q      <= '0;
      have1_q   <= 1'b0;
      have2_q   <= 1'b0;
      nxt_phi_q <= '0;
      c1_phi_q  <= '0;
    end else if (adv_i) begin
      c2_q      <= c1_q;
      have2_q   <= have1_q;
      c1_q      <= col_i;
      have1_q   <= 1'b1;
      c1_phi_q  <= nxt_phi_q;
      nxt_phi_q <= nxt_phi_q + 1'b1;
    end else if (flush_i) begin
      have1_q   <= 1'b0;
      have2_q   <= 1'b0;
      nxt_phi_q <= '0;
    end
  end

  // first column of a frame has no left neighbour
  assign prev_o       = have2_q ? c2_q : '0;
  assign cent_o       = c1_q;
  assign cent_valid_o = have1_q;
  assign cent_phi_o   = c1_phi_q;

  AST_PHI_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !adv_i |=> nxt_phi_q == '0 && !have1_q && !have2_q); // R8
endmodule

// File: rtl/lmf_peak_eval.sv
module lmf_peak_eval import lmf_pkg::*; #(
  parameter int N_CLASS = 8
) (
  input  logic [N_CLASS*CNT_W-1:0] prev_i,
  input  logic [N_CLASS*CNT_W-1:0] cent_i,
  input  logic [N_CLASS*CNT_W-1:0] next_i,
  input  logic [CNT_W-1:0]         thresh_i,
  output logic [N_CLASS-1:0]       hit_o
);
  // zero-padded by one class on each side
  logic [CNT_W-1:0] pv [N_CLASS+2];
  logic [CNT_W-1:0] cv [N_CLASS+2];
  logic [CNT_W-1:0] nv [N_CLASS+2];

  always_comb begin
    for (int i = 0; i < N_CLASS + 2; i++) begin
      pv[i] = '0;
      cv[i] = '0;
      nv[i] = '0;
    end
    for (int i = 0; i < N_CLASS; i++) begin
      pv[i+1] = prev_i[i*CNT_W +: CNT_W];
      cv[i+1] = cent_i[i*CNT_W +: CNT_W];
      nv[i+1] = next_i[i*CNT_W +: CNT_W];
    end
  end

  for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
    localparam int K = c + 1;
    logic [CNT_W-1:0] v;
    logic             beats_early, beats_late;
    assign v           = cv[K];
    // earlier neighbours need strict win, later ones only a tie
    assign beats_early = (v > pv[K-1]) && (v > pv[K]) && (v > pv[K+1]) && (v > cv[K-1]);
    assign beats_late  = (v >= cv[K+1]) && (v >= nv[K-1]) && (v >= nv[K]) && (v >= nv[K+1]);
    assign hit_o[c]    = (v > thresh_i) && beats_early && beats_late;
  end

  always_comb begin
    if (!$isunknown(hit_o))
      AST_NO_ADJACENT: assert ((hit_o & (hit_o >> 1)) == '0); // R2
  end
endmodule

// File: rtl/lmf_group_drain.sv
module lmf_group_drain import lmf_pkg::*; #(
  parameter int GRP_SIZE   = 4,
  parameter int CLS_W      = 3,
  parameter int BASE       = 0,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [GRP_SIZE-1:0]       hit_i,
  input  logic [GRP_SIZE*CNT_W-1:0] cnt_i,
  input  logic [PHI_W-1:0]          phi_i,
  output logic                      can_load_o,
  output logic                      rec_valid_o,
  input  logic                      rec_ready_i,
  output logic [CLS_W-1:0]          rec_class_o,
  output logic [PHI_W-1:0]          rec_phi_o,
  output logic [CNT_W-1:0]          rec_cnt_o
);
  localparam int IDX_W = (GRP_SIZE > 1) ? $clog2(GRP_SIZE) : 1;
  localparam int REC_W = CLS_W + PHI_W + CNT_W;

  logic [GRP_SIZE-1:0]       pend_q, sel;
  logic [GRP_SIZE*CNT_W-1:0] cnt_q;
  logic [PHI_W-1:0]          phi_q;
  logic [IDX_W-1:0]          idx;
  logic                      full, push;
  logic [REC_W-1:0]          din, dout;

  assign sel = pend_q & (~pend_q + 1'b1);

  always_comb begin
    idx = '0;
    for (int i = 0; i < GRP_SIZE; i++)
      if (sel[i]) idx = i[IDX_W-1:0];
  end

  assign push       = (|pend_q) & ~full;
  assign can_load_o = (pend_q == '0) | (((pend_q & (pend_q - 1'b1)) == '0) & ~full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cnt_q  <= '0;
      phi_q  <= '0;
    end else if (load_i) begin
      pend_q <= hit_i;
      cnt_q  <= cnt_i;
      phi_q  <= phi_i;
    end else if (push) begin
      pend_q <= pend_q & ~sel;
    end
  end

  assign din = {CLS_W'(BASE) + CLS_W'(idx), phi_q, cnt_q[idx*CNT_W +: CNT_W]};

  lmf_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (din),
    .full_o  (full),
    .valid_o (rec_valid_o),
    .ready_i (rec_ready_i),
    .dout_o  (dout)
  );

  assign {rec_class_o, rec_phi_o, rec_cnt_o} = dout;

  AST_LOAD_ONLY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> can_load_o); // R6
  AST_STALL_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0) && full |-> !can_load_o); // R6
endmodule

// File: rtl/lmf_peak_finder.sv
module lmf_peak_finder import lmf_pkg::*; #(
  parameter  int N_CLASS    = 8,
  parameter  int GRP_SIZE   = 4,
  parameter  int FIFO_DEPTH = 4,
  localparam int N_GRP      = N_CLASS / GRP_SIZE,
  localparam int CLS_W      = (N_CLASS > 1) ? $clog2(N_CLASS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CNT_W-1:0]         thresh_i,
  input  logic                     col_valid_i,
  input  logic [N_CLASS*CNT_W-1:0] col_data_i,
  input  logic                     eof_i,
  output logic                     col_ready_o,
  output logic [N_GRP-1:0]         rec_valid_o,
  input  logic [N_GRP-1:0]         rec_ready_i,
  output logic [N_GRP*CLS_W-1:0]   rec_class_o,
  output logic [N_GRP*PHI_W-1:0]   rec_phi_o,
  output logic [N_GRP*CNT_W-1:0]   rec_cnt_o
);
  logic [N_GRP-1:0]         can_load;
  logic                     accept_col, accept_eof, load;
  logic [N_CLASS*CNT_W-1:0] prev, cent, next_col;
  logic                     cent_valid;
  logic [PHI_W-1:0]         cent_phi;
  logic [N_CLASS-1:0]       hit_raw, hit;

  assign col_ready_o = &can_load;
  assign accept_col  = col_valid_i & col_ready_o;
  assign accept_eof  = eof_i & ~col_valid_i & col_ready_o;
  assign load        = accept_col | accept_eof;

  lmf_column_window #(.N_CLASS(N_CLASS)) u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (accept_col),
    .flush_i      (accept_eof),
    .col_i        (col_data_i),
    .prev_o       (prev),
    .cent_o       (cent),
    .cent_valid_o (cent_valid),
    .cent_phi_o   (cent_phi)
  );

  // end of frame supplies an empty right neighbour
  assign next_col = accept_col ? col_data_i : '0;

  lmf_peak_eval #(.N_CLASS(N_CLASS)) u_eval (
    .prev_i   (prev),
    .cent_i   (cent),
    .next_i   (next_col),
    .thresh_i (thresh_i),
    .hit_o    (hit_raw)
  );

  assign hit = (cent_valid & load) ? hit_raw : '0;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    lmf_group_drain #(
      .GRP_SIZE   (GRP_SIZE),
      .CLS_W      (CLS_W),
      .BASE       (g * GRP_SIZE),
      .FIFO_DEPTH (FIFO_DEPTH)
    ) u_drn (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .hit_i       (hit[g*GRP_SIZE +: GRP_SIZE]),
      .cnt_i       (cent[g*GRP_SIZE*CNT_W +: GRP_SIZE*CNT_W]),
      .phi_i       (cent_phi),
      .can_load_o  (can_load[g]),
      .rec_valid_o (rec_valid_o[g]),
      .rec_ready_i (rec_ready_i[g]),
      .rec_class_o (rec_class_o[g*CLS_W +: CLS_W]),
      .rec_phi_o   (rec_phi_o[g*PHI_W +: PHI_W]),
      .rec_cnt_o   (rec_cnt_o[g*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/test_lmf_peak_finder.sv
`timescale 1ns/1ps
module test_lmf_peak_finder;
  localparam int N = 8;
  localparam int G = 4;
  localparam int NG = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  thresh_i = 8'd0;
  logic        col_valid_i = 1'b0;
  logic [63:0] col_data_i = '0;
  logic        eof_i = 1'b0;
  logic        col_ready_o;
  logic [1:0]  rec_valid_o;
  logic [1:0]  rec_ready_i = 2'b11;
  logic [5:0]  rec_class_o;
  logic [19:0] rec_phi_o;
  logic [15:0] rec_cnt_o;

  always #4 clk = ~clk;

  lmf_peak_finder #(.N_CLASS(N), .GRP_SIZE(G), .FIFO_DEPTH(4)) i_lmf_peak_finder (
    .clk_i(clk), .rst_ni(rst_ni), .thresh_i(thresh_i), .col_valid_i(col_valid_i),
    .col_data_i(col_data_i), .eof_i(eof_i), .col_ready_o(col_ready_o),
    .rec_valid_o(rec_valid_o), .rec_ready_i(rec_ready_i), .rec_class_o(rec_class_o),
    .rec_phi_o(rec_phi_o), .rec_cnt_o(rec_cnt_o)
  );

  int checks = 0, failures = 0;
  int frm [64][N];
  int ncol = 0;
  int thr = 0;
  logic [20:0] q0 [$];
  logic [20:0] q1 [$];
  int mode = 0, stall_cnt = 0, rx_count = 0;
  bit run = 0, saw_stall = 0, done = 0;
  logic [31:0] seed = 32'h1234_5678;
  bit hold_v [NG];
  logic [20:0] hold_d [NG];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[23:16]);
  endfunction

  function automatic int val(int p, int c);
    if (p < 0 || p >= ncol || c < 0 || c >= N) return 0;
    return frm[p][c];
  endfunction

  // reference: peak rule with ordering phi then class
  task automatic eval_col(input int p);
    for (int c = 0; c < N; c++) begin
      int v;
      bit ok;
      v = val(p, c);
      ok = v > thr;
      for (int dp = -1; dp <= 1; dp++)
        for (int dc = -1; dc <= 1; dc++) begin
          int nb;
          bit early;
          if (dp == 0 && dc == 0) continue;
          nb = val(p + dp, c + dc);
          early = (dp < 0) || (dp == 0 && dc < 0);
          if (early ? !(v > nb) : !(v >= nb)) ok = 0;
        end
      if (ok) begin
        if (c / G == 0) q0.push_back({3'(c), 10'(p), 8'(v)});
        else            q1.push_back({3'(c), 10'(p), 8'(v)});
      end
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic send_col(input logic [63:0] d, input bit with_eof);
    col_valid_i = 1'b1;
    col_data_i  = d;
    eof_i       = with_eof;
    while (!col_ready_o) @(negedge clk);
    @(posedge clk);
    for (int c = 0; c < N; c++) frm[ncol][c] = int'(d[c*8 +: 8]);
    ncol++;
    if (ncol >= 2) eval_col(ncol - 2);
    @(negedge clk);
    col_valid_i = 1'b0;
    eof_i       = 1'b0;
  endtask

  task automatic send_eof();
    eof_i = 1'b1;
    while (!col_ready_o) @(negedge clk);
    @(posedge clk);
    if (ncol >= 1) eval_col(ncol - 1);
    ncol = 0;
    @(negedge clk);
    eof_i = 1'b0;
  endtask

  task automatic drain_wait(input string req);
    int n;
    n = 0;
    while ((q0.size() != 0 || q1.size() != 0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
    chk(q0.size() + q1.size() == 0, req, q0.size() + q1.size(), 0);
    chk(rec_valid_o == 2'b00, req, int'(rec_valid_o), 0);
  endtask

  // consumer and per-clock comparison
  always @(negedge clk) begin
    if (rst_ni && run) begin
      for (int g = 0; g < NG; g++) begin
        logic [20:0] got, exp;
        bit rdy;
        case (mode)
          1: rdy = (g != 0) || (stall_cnt >= 40);
          2: rdy = (rnd8() & 3) != 0;
          default: rdy = 1'b1;
        endcase
        rec_ready_i[g] = rdy;
        got = {rec_class_o[g*3 +: 3], rec_phi_o[g*10 +: 10], rec_cnt_o[g*8 +: 8]};
        if (hold_v[g])
          chk(rec_valid_o[g] && got == hold_d[g], "R7 record held", int'(got), int'(hold_d[g]));
        hold_v[g] = rec_valid_o[g] && !rdy;
        hold_d[g] = got;
        if (rec_valid_o[g] && rdy) begin
          rx_count++;
          if ((g == 0 ? q0.size() : q1.size()) == 0) begin
            chk(1'b0, "R2 unexpected record", int'(got), -1);
          end else begin
            exp = (g == 0) ? q0.pop_front() : q1.pop_front();
            chk(got == exp, "R4/R5 record fields and order", int'(got), int'(exp));
            chk(int'(got[7:0]) > thr, "R1 count above threshold", int'(got[7:0]), thr + 1);
          end
        end
      end
      if (mode == 1) stall_cnt++;
      if (!col_ready_o) saw_stall = 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    chk(rec_valid_o == 2'b00, "R9 no record after reset", int'(rec_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(col_ready_o == 1'b1, "R9 ready after reset", int'(col_ready_o), 1);
    chk(rec_valid_o == 2'b00, "R9 no record after reset", int'(rec_valid_o), 0);
    run = 1;

    // frame 1: pseudo-random bins
    thr = 20; thresh_i = 8'd20;
    for (int p = 0; p < 12; p++) begin
      for (int c = 0; c < N; c++) d[c*8 +: 8] = 8'(rnd8() & 63);
      send_col(d, 1'b0);
    end
    send_eof();
    drain_wait("R8 frame 1 flushed");

    // frame 2: corners, plateau, phi restart
    thr = 5; thresh_i = 8'd5;
    rx_count = 0;
    d = '0; d[7:0] = 8'd50;          send_col(d, 1'b0);
    d = '0; d[39:32] = 8'd30;        send_col(d, 1'b0);
    d = '0; d[39:32] = 8'd30;        send_col(d, 1'b0);
    d = '0; d[63:56] = 8'd40;        send_col(d, 1'b0);
    send_eof();
    drain_wait("R3 edge frame flushed");
    chk(rx_count == 3, "R3 corner and plateau peaks", rx_count, 3);

    // frame 3: threshold above every bin
    thr = 250; thresh_i = 8'd250;
    rx_count = 0;
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < N; c++) d[c*8 +: 8] = 8'(rnd8() % 250);
      send_col(d, 1'b0);
    end
    send_eof();
    drain_wait("R1 high threshold frame");
    chk(rx_count == 0, "R1 nothing above threshold", rx_count, 0);

    // frame 4: blocked queue 0, dense peaks
    thr = 10; thresh_i = 8'd10;
    mode = 1; stall_cnt = 0; saw_stall = 0;
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < N; c++)
        d[c*8 +: 8] = ((p % 2) == 0 && (c % 2) == 0) ? 8'(100 + (p*3 + c*5) % 7) : 8'd0;
      send_col(d, 1'b0);
    end
    send_eof();
    drain_wait("R6 backpressure frame");
    chk(saw_stall, "R6 input stalled by full queue", int'(saw_stall), 1);

    // frame 5: random consumer, eof raised together with a column
    mode = 2;
    thr = 60; thresh_i = 8'd60;
    for (int p = 0; p < 20; p++) begin
      for (int c = 0; c < N; c++) d[c*8 +: 8] = 8'(rnd8());
      send_col(d, p == 9);
    end
    send_eof();
    drain_wait("R8 eof with column ignored");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule